// File: doc/BRIEF.md
# UART FIFO Trigger and Flow Controller

This block tracks how full the receive and transmit FIFOs of a UART are and turns those levels into three signals. The first is a receive trigger flag. The second is a transmit trigger flag. The third is a request-to-send output that pauses the remote sender when the receiver fills up. The data storage, serial shifting and baud generation sit elsewhere. This block sees only push and pop strobes, and it tells the storage when to discard its contents.

The block has two operating depths. In the compact 32-entry mode, a 2-bit receive code and a 2-bit transmit code pick the thresholds from fixed tables. In the deep 128-entry mode, four 8-bit level registers set the thresholds directly:

- receive trigger
- transmit trigger
- flow-stop level
- flow-resume level

The deep mode is in force whenever any of the four registers is nonzero. A change of depth, or a toggle of the FIFO enable, discards the contents of both FIFOs. Changes to the transmit code are held back until the feature-unlock input is high.

Top module: `fifo_trig_ctl`

## Requirements
- R1: `ext_mode` is 1 in the cycle after any of `tx_lvl`, `rx_lvl`, `flow_hi`, `flow_lo` is nonzero, and 0 in the cycle after all four are zero; the occupancy limit is 128 when `ext_mode` is 1 and 32 when it is 0.
- R2: In 32-entry mode, `rx_trig` is 1 while `rx_cnt` is at least the receive threshold, where `rx_code` 0/1/2/3 gives 8/16/24/28.
- R3: In 32-entry mode, `tx_trig` is 1 while the free space (32 minus `tx_cnt`) is at least the transmit threshold, where the latched transmit code 0/1/2/3 gives 16/8/24/30.
- R4: In 32-entry mode, `rts_on` goes to 0 one cycle after `rx_cnt` reaches the stop level 8/16/24/28 for `rx_code` 0/1/2/3. It returns to 1 one cycle after `rx_cnt` is at or below the resume level 0/7/15/23. Between the two levels it holds its value.
- R5: `tx_code` is latched only in cycles where `tx_unlock` is 1. While `tx_unlock` is 0, the transmit threshold of R3 stays as last latched, and it is 16 after reset.
- R6: In 128-entry mode, the receive threshold is `rx_lvl` and the transmit threshold is `tx_lvl`, each clamped to the range 1 to 128 (0 acts as 1, above 128 acts as 128). The flags are formed as in R2 and R3 with 128 as the depth.
- R7: In 128-entry mode, `rts_on` goes to 0 one cycle after `rx_cnt` is at or above `flow_hi`. It returns to 1 one cycle after `rx_cnt` is at or below `flow_lo`, and holds otherwise.
- R8: `rx_flush` and `tx_flush` are 1 in any non-reset cycle where `fifo_en` differs from its value in the previous cycle, or where the mode of R1 is about to change. In the next cycle both counts are 0 and `rts_on` is 1.
- R9: A push is accepted only when the count is below the occupancy limit, and a pop only when the count is nonzero; accepted strobes move the count by +1 and -1 and cancel when both are accepted. Push and pop together on an empty FIFO give 1; on a full FIFO they give limit minus 1.
- R10: A synchronous `rst` clears both counts, sets `ext_mode` to 0, sets the latched transmit code to 0, sets `rts_on` to 1, and holds the flush outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO enable; any toggle flushes both FIFOs |
| tx_unlock | input | 1 | Allows `tx_code` to be latched |
| rx_code | input | 2 | Receive threshold code for 32-entry mode |
| tx_code | input | 2 | Transmit threshold code for 32-entry mode |
| tx_lvl | input | 8 | Transmit trigger level, 128-entry mode |
| rx_lvl | input | 8 | Receive trigger level, 128-entry mode |
| flow_hi | input | 8 | Receive level that stops the sender, 128-entry mode |
| flow_lo | input | 8 | Receive level that resumes the sender, 128-entry mode |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| rx_cnt | output | 8 | Receive occupancy |
| tx_cnt | output | 8 | Transmit occupancy |
| rx_trig | output | 1 | Receive trigger flag |
| tx_trig | output | 1 | Transmit trigger flag |
| rts_on | output | 1 | 1 lets the remote sender transmit |
| rx_flush | output | 1 | Discard pulse for receive storage |
| tx_flush | output | 1 | Discard pulse for transmit storage |
| ext_mode | output | 1 | 1 when 128-entry mode is active |

## Verification
Two events can land on the same clock edge. The first is a push and a pop on the same FIFO. The bench drives both strobes together on an empty FIFO, on a full FIFO and in the middle range, and compares the count with its own acceptance rules. The second is a flush together with pending strobes. The bench writes a level register, or toggles the enable, while pushes are still being driven, and checks that the count reads zero and `rts_on` reads 1 one cycle later.

// File: rtl/trig_pkg.sv
package trig_pkg;

  function automatic int unsigned leg_rx_thr(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 24;
      default: return 28;
    endcase
  endfunction

  function automatic int unsigned leg_tx_thr(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 8;
      2'd2:    return 24;
      default: return 30;
    endcase
  endfunction

  function automatic int unsigned leg_resume(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 7;
      2'd2:    return 15;
      default: return 23;
    endcase
  endfunction

  function automatic int unsigned clamp_lvl(input int unsigned lvl,
                                            input int unsigned top);
    if (lvl == 0)  return 1;
    if (lvl > top) return top;
    return lvl;
  endfunction

endpackage

// File: rtl/trig_occ_cnt.sv
module trig_occ_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt
);
  logic push_ok;
  logic pop_ok;

  assign push_ok = push && (cnt < limit);
  assign pop_ok  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || flush)          cnt <= '0;
    else if (push_ok && !pop_ok) cnt <= cnt + 1'b1;
    else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/trig_mode_ctl.sv
module trig_mode_ctl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          tx_unlock,
  input  logic [1:0]    tx_code,
  input  logic [CW-1:0] tx_lvl,
  input  logic [CW-1:0] rx_lvl,
  input  logic [CW-1:0] flow_hi,
  input  logic [CW-1:0] flow_lo,
  output logic          ext_q,
  output logic          flush,
  output logic [1:0]    tx_code_q
);
  logic ext_now;
  logic en_q;

  assign ext_now = |{tx_lvl, rx_lvl, flow_hi, flow_lo};
  assign flush   = !rst && ((fifo_en != en_q) || (ext_now != ext_q));

  always_ff @(posedge clk) begin
    en_q <= fifo_en;
    if (rst) begin
      ext_q     <= 1'b0;
      tx_code_q <= 2'd0;
    end else begin
      ext_q <= ext_now;
      if (tx_unlock) tx_code_q <= tx_code;
    end
  end
endmodule

// File: rtl/trig_rts_flow.sv
module trig_rts_flow #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] stop_lvl,
  input  logic [CW-1:0] resume_lvl,
  output logic          rts_on
);
  logic stop_ev;
  logic resume_ev;

  assign stop_ev   = cnt >= stop_lvl;
  assign resume_ev = cnt <= resume_lvl;

  always_ff @(posedge clk) begin
    if (rst || flush)   rts_on <= 1'b1;
    else if (stop_ev)   rts_on <= 1'b0;
    else if (resume_ev) rts_on <= 1'b1;
  end
endmodule

// File: rtl/fifo_trig_ctl.sv
module fifo_trig_ctl #(
  parameter int CW        = 8,
  parameter int LEG_DEPTH = 32,
  parameter int EXT_DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          tx_unlock,
  input  logic [1:0]    rx_code,
  input  logic [1:0]    tx_code,
  input  logic [CW-1:0] tx_lvl,
  input  logic [CW-1:0] rx_lvl,
  input  logic [CW-1:0] flow_hi,
  input  logic [CW-1:0] flow_lo,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          tx_push,
  input  logic          tx_pop,
  output logic [CW-1:0] rx_cnt,
  output logic [CW-1:0] tx_cnt,
  output logic          rx_trig,
  output logic          tx_trig,
  output logic          rts_on,
  output logic          rx_flush,
  output logic          tx_flush,
  output logic          ext_mode
);
  import trig_pkg::*;

  localparam logic [CW-1:0] LEG_LIM = CW'(LEG_DEPTH);
  localparam logic [CW-1:0] EXT_LIM = CW'(EXT_DEPTH);

  logic          flush;
  logic [1:0]    tx_code_q;
  logic [CW-1:0] act_depth;
  logic [CW-1:0] rx_thr;
  logic [CW-1:0] tx_thr;
  logic [CW-1:0] stop_lvl;
  logic [CW-1:0] resume_lvl;
  logic [CW-1:0] tx_free;

  trig_mode_ctl #(.CW(CW)) u_mode (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_unlock(tx_unlock),
    .tx_code(tx_code), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .flow_hi(flow_hi), .flow_lo(flow_lo),
    .ext_q(ext_mode), .flush(flush), .tx_code_q(tx_code_q)
  );

  assign act_depth = ext_mode ? EXT_LIM : LEG_LIM;

  trig_occ_cnt #(.CW(CW)) u_rx_cnt (
    .clk(clk), .rst(rst), .flush(flush), .push(rx_push), .pop(rx_pop),
    .limit(act_depth), .cnt(rx_cnt)
  );

  trig_occ_cnt #(.CW(CW)) u_tx_cnt (
    .clk(clk), .rst(rst), .flush(flush), .push(tx_push), .pop(tx_pop),
    .limit(act_depth), .cnt(tx_cnt)
  );

  always_comb begin
    if (ext_mode) begin
      rx_thr     = CW'(clamp_lvl(int'(rx_lvl), EXT_DEPTH));
      tx_thr     = CW'(clamp_lvl(int'(tx_lvl), EXT_DEPTH));
      stop_lvl   = flow_hi;
      resume_lvl = flow_lo;
    end else begin
      rx_thr     = CW'(leg_rx_thr(rx_code));
      tx_thr     = CW'(leg_tx_thr(tx_code_q));
      stop_lvl   = CW'(leg_rx_thr(rx_code));
      resume_lvl = CW'(leg_resume(rx_code));
    end
  end

  trig_rts_flow #(.CW(CW)) u_rts (
    .clk(clk), .rst(rst), .flush(flush), .cnt(rx_cnt),
    .stop_lvl(stop_lvl), .resume_lvl(resume_lvl), .rts_on(rts_on)
  );

  assign tx_free  = act_depth - tx_cnt;
  assign rx_trig  = rx_cnt >= rx_thr;
  assign tx_trig  = tx_free >= tx_thr;
  assign rx_flush = flush;
  assign tx_flush = flush;
endmodule

// File: rtl/trig_ctl_chk.sv
module trig_ctl_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rts_on,
  input logic          rx_flush,
  input logic          ext_mode,
  input logic [CW-1:0] act_depth
);
  // R9: occupancy never exceeds the active limit
  a_r9_rx_bound: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= act_depth);
  a_r9_tx_bound: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= act_depth);
  // R9: a lone pop on an empty FIFO is ignored
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == '0 && rx_pop && !rx_push && !rx_flush) |=> rx_cnt == '0);
  // R8: flush empties both FIFOs and releases the sender
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> (rx_cnt == '0 && tx_cnt == '0 && rts_on));
  // R8: an enable toggle always raises the flush
  a_r8_en_toggle: assert property (@(posedge clk) disable iff (rst)
    !$stable(fifo_en) |-> rx_flush);
  // R1: the mode only moves behind a flush or a reset
  a_r1_mode_flush: assert property (@(posedge clk) disable iff (rst)
    !$stable(ext_mode) |-> ($past(rx_flush) || $past(rst)));
endmodule

bind fifo_trig_ctl trig_ctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rts_on(rts_on), .rx_flush(rx_flush),
  .ext_mode(ext_mode), .act_depth(act_depth)
);

// File: tb/test_fifo_trig_ctl.sv
`timescale 1ns/1ps
module test_fifo_trig_ctl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, fifo_en, tx_unlock, rx_push, rx_pop, tx_push, tx_pop;
  logic [1:0] rx_code, tx_code;
  logic [7:0] tx_lvl, rx_lvl, flow_hi, flow_lo;
  logic [7:0] rx_cnt, tx_cnt;
  logic       rx_trig, tx_trig, rts_on, rx_flush, tx_flush, ext_mode;

  fifo_trig_ctl i_fifo_trig_ctl (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_unlock(tx_unlock),
    .rx_code(rx_code), .tx_code(tx_code), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .flow_hi(flow_hi), .flow_lo(flow_lo), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_trig(rx_trig), .tx_trig(tx_trig), .rts_on(rts_on),
    .rx_flush(rx_flush), .tx_flush(tx_flush), .ext_mode(ext_mode)
  );

  // shadow stimulus, copied to the pins at the falling edge
  bit       n_rst = 1, n_en = 1, n_unl = 0, n_rp = 0, n_rpo = 0, n_tp = 0, n_tpo = 0;
  bit [1:0] n_rc = 0, n_tc = 0;
  int       n_tl = 0, n_rl = 0, n_fh = 0, n_fl = 0;

  // reference state
  int m_rx = 0, m_tx = 0, m_txc = 0;
  bit m_ext = 0, m_en = 1, m_rts = 1;

  int rx_tab[4] = '{8, 16, 24, 28};
  int tx_tab[4] = '{16, 8, 24, 30};
  int rs_tab[4] = '{0, 7, 15, 23};

  typedef struct {
    string tag;
    int    rx, tx;
    bit    rtrg, ttrg, rts, ext;
  } exp_t;
  exp_t sb[$];

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lim(input int v);
    return (v < 1) ? 1 : ((v > 128) ? 128 : v);
  endfunction

  function automatic int next_cnt(input int c, input bit p, input bit q, input int d);
    int up, dn;
    up = (p && c < d) ? 1 : 0;
    dn = (q && c > 0) ? 1 : 0;
    return c + up - dn;
  endfunction

  task automatic step(input string tag);
    bit ext_now, fl;
    int dep, hi, lo;
    exp_t e;
    @(negedge clk);
    rst = n_rst; fifo_en = n_en; tx_unlock = n_unl; rx_code = n_rc; tx_code = n_tc;
    tx_lvl = 8'(n_tl); rx_lvl = 8'(n_rl); flow_hi = 8'(n_fh); flow_lo = 8'(n_fl);
    rx_push = n_rp; rx_pop = n_rpo; tx_push = n_tp; tx_pop = n_tpo;
    #1;
    ext_now = (n_tl != 0) || (n_rl != 0) || (n_fh != 0) || (n_fl != 0);
    fl = !n_rst && ((n_en != m_en) || (ext_now != m_ext));
    chk({tag, "/R8"}, "rx_flush", int'(rx_flush), int'(fl));
    chk({tag, "/R8"}, "tx_flush", int'(tx_flush), int'(fl));
    dep = m_ext ? 128 : 32;
    hi  = m_ext ? n_fh : rx_tab[n_rc];
    lo  = m_ext ? n_fl : rs_tab[n_rc];
    if (n_rst || fl) m_rts = 1;
    else if (m_rx >= hi) m_rts = 0;
    else if (m_rx <= lo) m_rts = 1;
    if (n_rst || fl) begin
      m_rx = 0; m_tx = 0;
    end else begin
      m_rx = next_cnt(m_rx, n_rp, n_rpo, dep);
      m_tx = next_cnt(m_tx, n_tp, n_tpo, dep);
    end
    m_en  = n_en;
    m_ext = n_rst ? 1'b0 : ext_now;
    if (n_rst) m_txc = 0;
    else if (n_unl) m_txc = n_tc;
    dep = m_ext ? 128 : 32;
    e.tag  = tag;
    e.rx   = m_rx;
    e.tx   = m_tx;
    e.rtrg = m_rx >= (m_ext ? lim(n_rl) : rx_tab[n_rc]);
    e.ttrg = (dep - m_tx) >= (m_ext ? lim(n_tl) : tx_tab[m_txc]);
    e.rts  = m_rts;
    e.ext  = m_ext;
    sb.push_back(e);
  endtask

  // monitor: judges the outputs just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "rx_cnt", int'(rx_cnt), e.rx);
        chk(e.tag, "tx_cnt", int'(tx_cnt), e.tx);
        chk(e.tag, "rx_trig", int'(rx_trig), int'(e.rtrg));
        chk(e.tag, "tx_trig", int'(tx_trig), int'(e.ttrg));
        chk(e.tag, "rts_on", int'(rts_on), int'(e.rts));
        chk(e.tag, "ext_mode", int'(ext_mode), int'(e.ext));
      end
    end
  end

  task automatic strobes(input bit rp, input bit rpo, input bit tp, input bit tpo);
    n_rp = rp; n_rpo = rpo; n_tp = tp; n_tpo = tpo;
  endtask

  initial begin
    // R10: reset state
    n_rst = 1;
    step("R10"); step("R10");
    n_rst = 0;
    step("R10");

    // R2 and R4: receive fill and drain with code 0
    strobes(1, 0, 0, 0);
    repeat (10) step("R2");
    strobes(0, 1, 0, 0);
    repeat (11) step("R4");

    // R4: hysteresis band with code 2
    n_rc = 2'd2;
    strobes(1, 0, 0, 0);
    repeat (27) step("R4");
    strobes(0, 1, 0, 0);
    repeat (14) step("R4");
    n_rc = 2'd3;
    repeat (2) step("R2");
    n_rc = 2'd1;
    repeat (16) step("R4");

    // R5: transmit code held until unlock
    n_tc = 2'd1; n_unl = 0;
    strobes(0, 0, 1, 0);
    repeat (20) step("R5");
    strobes(0, 0, 0, 0);
    n_unl = 1; step("R5");
    n_unl = 0; n_tc = 2'd3; step("R5");
    // R3: every transmit code at this level
    for (int c = 0; c < 4; c++) begin
      n_tc = 2'(c); n_unl = 1;
      step("R3"); step("R3");
    end
    n_unl = 0;

    // R9: saturation and simultaneous strobes
    strobes(0, 0, 1, 0);
    repeat (15) step("R9");
    strobes(0, 0, 1, 1); step("R9");
    strobes(0, 0, 0, 1);
    repeat (40) step("R9");
    strobes(0, 0, 1, 1); step("R9"); step("R9");
    strobes(1, 1, 0, 0); step("R9");

    // R8: enable toggle while strobes are live
    strobes(1, 0, 1, 0);
    repeat (12) step("R8");
    n_en = 0; step("R8");
    repeat (3) step("R8");
    n_en = 1; step("R8");
    step("R8");

    // R1, R6, R7: deep mode entry flushes, then thresholds from levels
    n_rl = 40; n_fh = 60; n_fl = 20; n_tl = 100;
    step("R1");
    strobes(1, 0, 1, 0);
    repeat (70) step("R6");
    strobes(0, 1, 0, 0);
    repeat (55) step("R7");
    strobes(1, 0, 0, 0);
    repeat (45) step("R7");
    n_tl = 0; step("R6");
    n_tl = 200; step("R6");
    n_rl = 0; step("R6");
    repeat (90) step("R9");
    strobes(1, 1, 0, 0); step("R9");
    strobes(0, 0, 0, 0);

    // R1: all levels cleared returns to 32-entry mode
    n_tl = 0; n_fh = 0; n_fl = 0;
    step("R1");
    step("R1");

    // R10: reset in the middle of activity
    strobes(1, 0, 1, 0);
    repeat (5) step("R10");
    n_rst = 1; step("R10");
    n_rst = 0; strobes(0, 0, 0, 0); step("R10");
    step("R10");

    repeat (2) @(posedge clk);
    #5;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule